// File: doc/BRIEF.md
# Maskable Repeating Alarm Generator

This block holds four alarm registers for seconds, minutes, hours and date. It compares them against a BCD time-of-day supplied by an external counter. On every one-second tick strobe it checks for a match. When the alarm condition is met, it emits a single-cycle interrupt pulse.

Bit 7 of each alarm register is a repeat mask that makes its field "don't care". The pattern of mask bits selects how often the alarm recurs: once a month, once a day, once an hour, once a minute or once a second.

Software reaches the registers through a byte-wide port inside a small address window. A write whose BCD content is out of range for its field is dropped, and the register keeps its old value.

Top module: `tod_alarm`

## Requirements
- R1: The registers sit at REG_BASE+0 (seconds), +1 (minutes), +2 (hours) and +3 (date). A read at one of these addresses returns the full stored byte, including the mask bit 7. A read at any other address returns 0.
- R2: A write to an address outside the four-register window changes no alarm register. With wrEn low, no register changes.
- R3: Writes to seconds or minutes are taken only when the BCD value of bits 6:0 is at most 59. The value is tens = bits 6:4 and units = bits 3:0, computed as tens*10 + units. When taken, all 8 written bits are stored.
- R4: Writes to hours are taken only when the BCD value of bits 5:0 is at most 23. Here tens = bits 5:4 and units = bits 3:0.
- R5: Writes to date are taken only when the BCD value of bits 4:0 is non-zero. Here tens = bit 4 and units = bits 3:0.
- R6: A write that is not taken leaves the register at its previous value.
- R7: With all four mask bits clear, the alarm fires when every field matches. A field matches when its value bits are equal: seconds and minutes bits 6:0, hours bits 5:0, date bits 4:0. Time-input bits outside these ranges are ignored.
- R8: With only the date mask set, the alarm fires when hours, minutes and seconds match.
- R9: With only the date and hours masks set, the alarm fires when minutes and seconds match.
- R10: With only the date, hours and minutes masks set, the alarm fires when seconds match.
- R11: Every other mask combination fires on every tick.
- R12: Matching is evaluated only on a cycle where secTick is high. alarmIrq goes high for exactly one cycle, in the cycle after the clock edge that samples the tick.
- R13: After reset all four registers read 0 and alarmIrq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| todSec | input | 8 | Current seconds, BCD |
| todMin | input | 8 | Current minutes, BCD |
| todHour | input | 8 | Current hours, BCD |
| todDate | input | 8 | Current day of month, BCD |
| secTick | input | 1 | One-cycle strobe, once per second |
| alarmIrq | output | 1 | Single-cycle alarm interrupt pulse |

## Verification
The bench builds the block with ADDR_W = 3 and REG_BASE = 3. The window is therefore unaligned, and four of the eight addresses lie outside it. This lets the bench drive every address and check both the in-window and out-of-window decode.

At this size, every one of the 256 byte values can be written to each of the four registers and read back. Every acceptance boundary is therefore crossed, including non-decimal digits.

The bench also sweeps all 16 mask combinations against all 16 patterns of which fields match. This exhausts the recurrence decode.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int DATA_W  = 8;
  localparam int FIELD_N = 4;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;

  typedef enum logic [2:0] {
    RATE_MONTH,
    RATE_DAY,
    RATE_HOUR,
    RATE_MIN,
    RATE_SEC
  } rate_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [FIELD_N-1:0] wrSel;
  } dp_cmd_t;

  // datapath -> control status
  typedef struct packed {
    logic [FIELD_N-1:0] fieldEq;
    logic [FIELD_N-1:0] maskBits;
  } dp_stat_t;

  // value bits that belong to a field
  function automatic logic [DATA_W-1:0] fieldMask(int idx);
    case (idx)
      F_HOUR:  return 8'h3F;
      F_DATE:  return 8'h1F;
      default: return 8'h7F;
    endcase
  endfunction

  // range rule applied to an incoming write
  function automatic logic valueOk(int idx, logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] m;
    logic [DATA_W-1:0] dec;
    m   = v & fieldMask(idx);
    dec = (m >> 4) * 8'd10 + (m & 8'h0F);
    case (idx)
      F_HOUR:  return dec <= 8'd23;
      F_DATE:  return dec != 8'd0;
      default: return dec <= 8'd59;
    endcase
  endfunction
endpackage

// File: rtl/tod_alarm_dp.sv
module tod_alarm_dp
  import tod_alarm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  dp_cmd_t                     cmd,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [FIELD_N*DATA_W-1:0]   todVec,
  output logic [FIELD_N*DATA_W-1:0]   regsFlat,
  output dp_stat_t                    stat
);
  for (genvar g = 0; g < FIELD_N; g++) begin : g_field
    logic [DATA_W-1:0] alarmReg;
    logic [DATA_W-1:0] todField;
    logic              acceptWr;

    assign todField = todVec[g*DATA_W +: DATA_W];
    assign acceptWr = cmd.wrSel[g] && valueOk(g, wrData);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        alarmReg <= '0;
      end else if (acceptWr) begin
        alarmReg <= wrData;
      end
    end

    assign regsFlat[g*DATA_W +: DATA_W] = alarmReg;
    assign stat.fieldEq[g]  = ((alarmReg ^ todField) & fieldMask(g)) == '0;
    assign stat.maskBits[g] = alarmReg[DATA_W-1];
  end
endmodule

// File: rtl/tod_alarm_ctrl.sv
module tod_alarm_ctrl
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              secTick,
  input  dp_stat_t          stat,
  output dp_cmd_t           cmd,
  output logic [FIELD_N-1:0] rdSel,
  output logic              alarmIrq
);
  localparam int OFF_W = ADDR_W + 1;

  logic [OFF_W-1:0] offs;
  logic             inWin;
  rate_e            rate;
  logic             hit;

  assign offs  = {1'b0, addr} - OFF_W'(REG_BASE);
  assign inWin = ({1'b0, addr} >= OFF_W'(REG_BASE)) && (offs < OFF_W'(FIELD_N));

  for (genvar g = 0; g < FIELD_N; g++) begin : g_sel
    assign rdSel[g] = inWin && (offs == OFF_W'(g));
  end

  assign cmd.wrSel = wrEn ? rdSel : '0;

  // recurrence selected by the mask pattern (bit3 date .. bit0 seconds)
  always_comb begin
    case (stat.maskBits)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end

  always_comb begin
    case (rate)
      RATE_MONTH: hit = &stat.fieldEq;
      RATE_DAY:   hit = &stat.fieldEq[F_HOUR:F_SEC];
      RATE_HOUR:  hit = &stat.fieldEq[F_MIN:F_SEC];
      RATE_MIN:   hit = stat.fieldEq[F_SEC];
      default:    hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmIrq <= 1'b0;
    end else begin
      alarmIrq <= secTick && hit;
    end
  end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [7:0]        todSec,
  input  logic [7:0]        todMin,
  input  logic [7:0]        todHour,
  input  logic [7:0]        todDate,
  input  logic              secTick,
  output logic              alarmIrq
);
  dp_cmd_t                    cmd;
  dp_stat_t                   stat;
  logic [FIELD_N-1:0]         rdSel;
  logic [FIELD_N*DATA_W-1:0]  regsFlat;
  logic [FIELD_N*DATA_W-1:0]  todVec;

  assign todVec = {todDate, todHour, todMin, todSec};

  tod_alarm_ctrl #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .secTick  (secTick),
    .stat     (stat),
    .cmd      (cmd),
    .rdSel    (rdSel),
    .alarmIrq (alarmIrq)
  );

  tod_alarm_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .wrData   (wrData),
    .todVec   (todVec),
    .regsFlat (regsFlat),
    .stat     (stat)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < FIELD_N; i++) begin
      if (rdSel[i]) rdData = regsFlat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
  parameter int ADDR_W   = 4,
  parameter int REG_BASE = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic              secTick,
  input logic              alarmIrq,
  input logic [31:0]       regsFlat
);
  logic [7:0] secDec;
  assign secDec = {5'b0, wrData[6:4]} * 8'd10 + {4'b0, wrData[3:0]};

  assert_irq_needs_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> $past(secTick));

  assert_irq_one_cycle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIrq && !secTick) |=> !alarmIrq);

  assert_all_masked_fires_R11: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && regsFlat[7] && regsFlat[15] && regsFlat[23] && regsFlat[31]) |=> alarmIrq);

  assert_idle_regs_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(regsFlat));

  assert_bad_sec_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(REG_BASE) && secDec > 8'd59) |=> $stable(regsFlat[7:0]));

  assert_good_date_taken_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(REG_BASE + 3) && wrData[4:0] != 5'd0)
      |=> regsFlat[31:24] == $past(wrData));
endmodule

bind tod_alarm tod_alarm_chk #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .secTick  (secTick),
  .alarmIrq (alarmIrq),
  .regsFlat (regsFlat)
);

// File: tb/test_tod_alarm.sv
`timescale 1ns/1ps
module test_tod_alarm;
  localparam int AW   = 3;
  localparam int BASE = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [AW-1:0] addr;
  logic [7:0]    wrData;
  logic [7:0]    rdData;
  logic [7:0]    todSec, todMin, todHour, todDate;
  logic          secTick;
  logic          alarmIrq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [4];
  logic [7:0] alarmBase [4];

  tod_alarm #(.ADDR_W(AW), .REG_BASE(BASE)) i_tod_alarm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .todSec(todSec), .todMin(todMin), .todHour(todHour),
    .todDate(todDate), .secTick(secTick), .alarmIrq(alarmIrq)
  );

  always #2.5 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expOk(int idx, int v);
    int tens, units;
    units = v & 15;
    case (idx)
      2: begin tens = (v >> 4) & 3; return tens * 10 + units <= 23; end
      3: begin tens = (v >> 4) & 1; return tens * 10 + units != 0; end
      default: begin tens = (v >> 4) & 7; return tens * 10 + units <= 59; end
    endcase
  endfunction

  // m: mask pattern (bit3 date..bit0 sec); p: which fields equal
  function automatic bit expFire(int m, int p);
    case (m)
      0:  return p == 15;
      8:  return (p & 7) == 7;
      12: return (p & 3) == 3;
      14: return (p & 1) == 1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic writeReg(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(int a, int exp, string req);
    addr = AW'(a);
    #0.5;
    check(rdData == 8'(exp), req, rdData, exp);
  endtask

  task automatic tickCheck(bit exp, string req);
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    check(alarmIrq == exp, req, alarmIrq, exp);
    @(negedge clk);
    check(alarmIrq == 1'b0, "R12 pulse width", alarmIrq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; secTick = 1'b0;
    todSec = '0; todMin = '0; todHour = '0; todDate = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R13: reset state
    check(alarmIrq == 1'b0, "R13 irq", alarmIrq, 0);
    for (int r = 0; r < 4; r++) begin
      model[r] = 8'h00;
      readCheck(BASE + r, 0, "R13 reg");
    end

    // R3 R4 R5 R6: exhaustive byte sweep per register
    for (int r = 0; r < 4; r++) begin
      for (int v = 0; v < 256; v++) begin
        writeReg(BASE + r, v);
        if (expOk(r, v)) model[r] = 8'(v);
        case (r)
          0, 1: readCheck(BASE + r, model[r], "R3 R6 sec/min write");
          2:    readCheck(BASE + r, model[r], "R4 R6 hour write");
          default: readCheck(BASE + r, model[r], "R5 R6 date write");
        endcase
      end
    end

    // R1 R2: outside window writes ignored, reads return 0
    for (int a = 0; a < 8; a++) begin
      if (a < BASE || a >= BASE + 4) writeReg(a, 8'h11);
    end
    for (int a = 0; a < 8; a++) begin
      if (a < BASE || a >= BASE + 4) readCheck(a, 0, "R1 out-of-window read");
      else readCheck(a, model[a - BASE], "R2 window untouched");
    end

    // R7..R11: all mask combinations x all match patterns
    alarmBase[0] = 8'h30; alarmBase[1] = 8'h15;
    alarmBase[2] = 8'h12; alarmBase[3] = 8'h07;
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 4; r++) begin
        writeReg(BASE + r, alarmBase[r] | (((m >> r) & 1) != 0 ? 8'h80 : 8'h00));
        readCheck(BASE + r, alarmBase[r] | (((m >> r) & 1) != 0 ? 8'h80 : 8'h00),
                  "R1 mask bit readback");
      end
      for (int p = 0; p < 16; p++) begin
        // upper bits outside each field carry junk that must be ignored
        todSec  = ((p & 1) != 0 ? 8'h30 : 8'h31) | 8'h80;
        todMin  = ((p & 2) != 0 ? 8'h15 : 8'h14);
        todHour = ((p & 4) != 0 ? 8'h12 : 8'h13) | 8'hC0;
        todDate = ((p & 8) != 0 ? 8'h07 : 8'h06) | 8'hE0;
        case (m)
          0:  tickCheck(expFire(m, p), "R7 monthly");
          8:  tickCheck(expFire(m, p), "R8 daily");
          12: tickCheck(expFire(m, p), "R9 hourly");
          14: tickCheck(expFire(m, p), "R10 minutely");
          default: tickCheck(expFire(m, p), "R11 every second");
        endcase
      end
    end

    // R12: a full match without a tick raises nothing
    for (int r = 0; r < 4; r++) writeReg(BASE + r, alarmBase[r]);
    todSec = 8'h30; todMin = 8'h15; todHour = 8'h12; todDate = 8'h07;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(alarmIrq == 1'b0, "R12 no tick", alarmIrq, 0);
    end
    tickCheck(1'b1, "R12 tick match");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule